// File: doc/BRIEF.md
# Cascadable Shift-and-Hold Sink Driver Core

This block is the digital core of an eight-channel serial-loaded LED sink driver. A host streams bits into an eight-stage shift register, one bit per shift strobe, and the last stage is brought out on a serial output. Several cores can therefore be chained, each passing its oldest bits to the next. A level-sensitive hold enable copies the register into eight holding latches. While the enable is high the latches follow the register, and while it is low they keep their value. Each latched one turns its channel's sink on.

Two gating inputs turn every channel off without touching stored data. One is an active-low output enable, used for inter-digit blanking. The other is an undervoltage flag that stands in for a supply monitor. The block runs on one system clock. `shift_en` is a single-cycle pulse that marks a rising edge of the external shift clock, detected upstream of this block.

Top module: `sink_drv_core`

## Requirements
- R1: On a cycle with `shift_en` high, register bit i+1 takes bit i and bit 0 takes `sdi`. On other cycles the register is unchanged.
- R2: `sdo` is register bit 7. After eight shifts the first bit sent is on `sdo`, and the following shifts present the older contents from bit 7 down to bit 0.
- R3: While `hold_en` is high the latches are transparent, so `sink_on` reflects a shift in the cycle after that shift's clock edge.
- R4: While `hold_en` is low the latches keep their value, whatever is shifted in.
- R5: With `blank_n` high every bit of `sink_on` is 0.
- R6: With `uv_flag` high every bit of `sink_on` is 0.
- R7: Raising and then lowering `blank_n` or `uv_flag` leaves the latch and register contents unchanged.
- R8: With both gates inactive, `sink_on[i]` equals latch bit i, and a 1 means the sink is on.
- R9: Synchronous active-high `rst` clears the register and the latches to zero, and `sink_on` is all zero while `rst` is high.
- R10: `sdo` changes only on a shift cycle. It does not change on `hold_en`, `blank_n` or `uv_flag` activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data in |
| shift_en | input | 1 | One-cycle pulse marking a shift-clock rising edge |
| hold_en | input | 1 | Latch transparency control, level sensitive |
| blank_n | input | 1 | High blanks all channels (active-low output enable) |
| uv_flag | input | 1 | Undervoltage condition; forces all channels off |
| sdo | output | 1 | Serial data out, last register stage |
| sink_on | output | 8 | Per-channel sink on |

## Verification
The first corner case is the cascade order on `sdo`. A core that takes its output from the wrong end, or that reverses the shift direction, sends the previous frame's bits in the wrong order. A second case is a hold enable that acts as an edge strobe instead of a transparent latch: it leaves `sink_on` one shift behind while the enable stays high. A third case is a core that lets new shifts leak into the latches while the enable is low. The last cases cover gating: blanking or undervoltage that clears the latches, and therefore loses the pattern when the gate is released, and an `sdo` that moves when the enables toggle.

// File: rtl/sink_drv_pkg.sv
package sink_drv_pkg;
    localparam int CH_DEF = 8;

    typedef struct packed {
        logic blank_n;
        logic uv_flag;
        logic rst;
    } gate_ctl_t;

    function automatic logic gate_off(input gate_ctl_t g);
        return g.blank_n | g.uv_flag | g.rst;
    endfunction
endpackage

// File: rtl/sink_shift_reg.sv
module sink_shift_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdi,
    input  logic         shift_en,
    output logic [N-1:0] sr_q,
    output logic [N-1:0] sr_nxt
);
    always_comb begin
        sr_nxt = sr_q;
        if (shift_en) sr_nxt = {sr_q[N-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_nxt;
    end

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr_q == {$past(sr_q[N-2:0]), $past(sdi)}); // R1
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr_q)); // R1
endmodule

// File: rtl/sink_hold_latch.sv
module sink_hold_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_en,
    input  logic [N-1:0] sr_q,
    input  logic [N-1:0] sr_nxt,
    output logic [N-1:0] view
);
    logic [N-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (hold_en) hold_q <= sr_nxt;
    end

    assign view = hold_en ? sr_q : hold_q;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        !hold_en |=> $stable(hold_q)); // R4
endmodule

// File: rtl/sink_out_gate.sv
module sink_out_gate
    import sink_drv_pkg::*;
#(
    parameter int N = 8
) (
    input  gate_ctl_t    ctl,
    input  logic [N-1:0] view,
    output logic [N-1:0] sink_on
);
    logic off;
    assign off = gate_off(ctl);

    for (genvar i = 0; i < N; i++) begin : g_ch
        assign sink_on[i] = view[i] & ~off;
    end
endmodule

// File: rtl/sink_drv_core.sv
module sink_drv_core
    import sink_drv_pkg::*;
#(
    parameter int CH = CH_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sdi,
    input  logic          shift_en,
    input  logic          hold_en,
    input  logic          blank_n,
    input  logic          uv_flag,
    output logic          sdo,
    output logic [CH-1:0] sink_on
);
    localparam int MSB = CH - 1;

    logic [CH-1:0] sr_q, sr_nxt, view;
    gate_ctl_t     ctl;

    assign ctl = '{blank_n: blank_n, uv_flag: uv_flag, rst: rst};

    sink_shift_reg #(.N(CH)) u_sr (
        .clk(clk), .rst(rst), .sdi(sdi), .shift_en(shift_en),
        .sr_q(sr_q), .sr_nxt(sr_nxt)
    );

    sink_hold_latch #(.N(CH)) u_hold (
        .clk(clk), .rst(rst), .hold_en(hold_en),
        .sr_q(sr_q), .sr_nxt(sr_nxt), .view(view)
    );

    sink_out_gate #(.N(CH)) u_gate (
        .ctl(ctl), .view(view), .sink_on(sink_on)
    );

    assign sdo = sr_q[MSB];

    AST_SDO_STILL: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sdo)); // R10
    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (rst)
        blank_n |-> sink_on == '0); // R5
    AST_UV_OFF: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> sink_on == '0); // R6
    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (hold_en && !blank_n && !uv_flag) |-> sink_on == sr_q); // R3
endmodule

// File: tb/sim_sink_drv_core.sv
`timescale 1ns/1ps
module sim_sink_drv_core;
    logic clk = 0, rst = 1, sdi = 0, shift_en = 0, hold_en = 0, blank_n = 1, uv_flag = 0;
    logic       sdo;
    logic [7:0] sink_on;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sink_drv_core u0 (
        .clk(clk), .rst(rst), .sdi(sdi), .shift_en(shift_en), .hold_en(hold_en),
        .blank_n(blank_n), .uv_flag(uv_flag), .sdo(sdo), .sink_on(sink_on)
    );

    // {data, blank_n, uv_flag, expected sink_on}
    localparam logic [17:0] VECS [0:6] = '{
        {8'hA5, 1'b0, 1'b0, 8'hA5},
        {8'h3C, 1'b1, 1'b0, 8'h00},
        {8'hFF, 1'b0, 1'b1, 8'h00},
        {8'h01, 1'b0, 1'b0, 8'h01},
        {8'h80, 1'b0, 1'b0, 8'h80},
        {8'h00, 1'b0, 1'b0, 8'h00},
        {8'h5A, 1'b1, 1'b1, 8'h00}
    };

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sdi = b; shift_en = 1; tick; shift_en = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        @(negedge clk);
        tick; tick;
        chk("R9 sink during reset", sink_on, 8'h00);
        rst = 0; blank_n = 0; hold_en = 1; tick;
        chk("R9 sink after reset", sink_on, 8'h00);
        chk("R9 sdo after reset", {7'd0, sdo}, 8'h00);
        hold_en = 0;
        prev = 8'h00;
        for (int v = 0; v < 7; v++) begin
            logic [7:0] d, e;
            d = VECS[v][17:10]; e = VECS[v][7:0];
            blank_n = VECS[v][9]; uv_flag = VECS[v][8];
            for (int j = 7; j >= 0; j--) begin
                chk("R2 cascade sdo", {7'd0, sdo}, {7'd0, prev[j]});
                shift_bit(d[j]);
            end
            hold_en = 1; tick; hold_en = 0; tick;
            chk("R8/R5/R6 frame sink", sink_on, e);
            prev = d;
        end
        // latches hold 5A, gates active
        blank_n = 0; uv_flag = 0; tick;
        chk("R7 data kept across gating", sink_on, 8'h5A);
        blank_n = 1; #1;
        chk("R5 blank", sink_on, 8'h00);
        blank_n = 0; uv_flag = 1; #1;
        chk("R6 undervoltage", sink_on, 8'h00);
        uv_flag = 0; #1;
        chk("R7 restored", sink_on, 8'h5A);
        for (int j = 7; j >= 0; j--) shift_bit(j[0] ? (8'hC3 >> j) & 1 : (8'hC3 >> j) & 1);
        chk("R4 hold while shifting", sink_on, 8'h5A);
        chk("R10 sdo before toggles", {7'd0, sdo}, 8'h01);
        hold_en = 1; blank_n = 1; tick; blank_n = 0; tick;
        chk("R10 sdo after toggles", {7'd0, sdo}, 8'h01);
        chk("R3 transparent", sink_on, 8'hC3);
        shift_bit(1'b0);
        chk("R3 follows shift", sink_on, 8'h86);
        chk("R1 shift", sink_on, {8'hC3 << 1});
        hold_en = 0;
        shift_bit(1'b1);
        chk("R4 hold after close", sink_on, 8'h86);
        chk("R2 sdo bit7", {7'd0, sdo}, 8'h00);
        rst = 1; tick;
        chk("R9 reset clears sink", sink_on, 8'h00);
        chk("R9 reset clears sdo", {7'd0, sdo}, 8'h00);
        rst = 0; hold_en = 1; tick;
        chk("R9 latches cleared", sink_on, 8'h00);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule